// File: doc/BRIEF.md
# Multi-Format PCM Sample Converter

This block sits at the edge of an audio datapath and converts samples between a 16-bit external field and the 16-bit two's-complement linear form used everywhere inside. A 2-bit global format select picks one of four external types: 16-bit signed linear, 8-bit unsigned linear, 8-bit mu-law or 8-bit A-law. Every 8-bit type sits in the upper byte of the 16-bit field, so the most significant bits line up and full scale means the same signal level in every format. Bits are weighted MSB first.

The playback side takes a host word with a valid strobe and returns a linear sample one cycle later. The capture side takes a linear sample with its own valid strobe and returns the word in the selected format one cycle later. The two sides run independently and may fire in the same cycle. The format select is copied into the block only in a cycle where neither side presents a sample, so a format change never splits a stream of back-to-back samples.

Top module: `pcm_fmt_conv`

## Requirements
- R1: While reset is held and on the first cycle after it, both output valids are low and both output data buses read 0x0000.
- R2: Each output valid is high exactly in the cycle after its input valid was high at a clock edge. The result appears in that same cycle, and the two directions do not affect each other.
- R3: With format code 0 (16-bit linear), the word passes unchanged in both directions.
- R4: With format code 1 (8-bit unsigned), decoding inverts bit 15 and keeps bits 14..8, giving {~w[15], w[14:8], 8'h00}. Encoding produces {~s[15], s[14:8], 8'h00}.
- R5: With format code 2 (mu-law), decoding complements the code byte u = ~w[15:8]. Bit 7 of u is the sign (1 = negative), bits 6..4 are the segment e and bits 3..0 the step m. The magnitude is (8m+132)*2^e - 132.
- R6: Mu-law encoding clips the magnitude at 32635, adds 132, and takes e from the highest set bit among bits 14..7 of that sum. The step is bits e+6..e+3 of the sum, and the code is ~{sign, e, m}. 0 encodes to 0xFF, +32767 to 0x80 and -32768 to 0x00.
- R7: With format code 3 (A-law), decoding XORs the code byte with 0x55. Bit 7 set means positive, bits 6..4 are the segment s and bits 3..0 the step m. The magnitude is 16m+8 for s=0, and (16m+264)*2^(s-1) otherwise.
- R8: A-law encoding forms a 12-bit magnitude q from bits 14..3, with those bits inverted for negative samples. The segment is 0 for q<32, and otherwise the bit position of q's MSB minus 4. The step is q[4:1] for segments 0 and 1, and q>>s for the others. The code is {~sign, s, m} ^ 0x55. 0 encodes to 0xD5, -1 to 0x55 and +32767 to 0xAA.
- R9: For the three 8-bit formats, the low byte of a playback word has no effect on the result, and the low byte of every capture output is zero.
- R10: The format select is taken only at a clock edge where both input valids are low. A change made while either valid stays high applies to no sample until one such idle edge has passed.
- R11: When an input valid is low, that side's output data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Format code: 0 linear16, 1 unsigned8, 2 mu-law, 3 A-law |
| play_vld | input | 1 | Playback word valid |
| play_word | input | 16 | Playback word in the external format |
| play_lin_vld | output | 1 | Decoded linear sample valid |
| play_lin | output | 16 | Decoded two's-complement sample |
| cap_vld | input | 1 | Capture sample valid |
| cap_lin | input | 16 | Capture two's-complement sample |
| cap_word_vld | output | 1 | Encoded word valid |
| cap_word | output | 16 | Encoded word in the external format |

## Verification
Both conversions pass through one register, so each result is due in the cycle that follows the edge where its strobe was seen. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after the capturing rising edge. A format write takes one idle edge to land. The bench therefore spends one falling-edge slot with both strobes low after each change before sending samples. In the switching test it holds a strobe high on purpose and expects the old format to remain in use until the first idle edge.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned FMT_W    = 2;
  localparam int unsigned PAD_W    = SAMPLE_W - CODE_W;

  localparam logic [SAMPLE_W-1:0] MU_BIAS   = 16'd132;
  localparam logic [SAMPLE_W-1:0] MU_CLIP   = 16'd32635;
  localparam logic [CODE_W-1:0]   ALAW_MASK = 8'h55;

  typedef enum logic [FMT_W-1:0] {
    FMT_LIN16 = 2'd0,
    FMT_ULIN8 = 2'd1,
    FMT_MULAW = 2'd2,
    FMT_ALAW  = 2'd3
  } pcm_fmt_e;

  // unsigned 8-bit <-> linear: offset binary differs only in the sign bit
  function automatic logic [SAMPLE_W-1:0] ulin8_expand(input logic [CODE_W-1:0] c);
    return {~c[CODE_W-1], c[CODE_W-2:0], {PAD_W{1'b0}}};
  endfunction

  function automatic logic [CODE_W-1:0] ulin8_compress(input logic [SAMPLE_W-1:0] s);
    return {~s[SAMPLE_W-1], s[SAMPLE_W-2:PAD_W]};
  endfunction

  // mu-law code -> linear, segment midpoint
  function automatic logic [SAMPLE_W-1:0] ulaw_expand(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0]   u;
    logic [SAMPLE_W-1:0] m;
    u = ~c;
    m = {9'd0, u[3:0], 3'd0} + MU_BIAS;
    m = (m << u[6:4]) - MU_BIAS;
    return u[7] ? (16'd0 - m) : m;
  endfunction

  // linear -> mu-law code
  function automatic logic [CODE_W-1:0] ulaw_compress(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] mag;
    logic [2:0]          ex;
    logic [3:0]          mant;
    mag = s[15] ? (16'd0 - s) : s;
    if (mag > MU_CLIP) mag = MU_CLIP;
    mag = mag + MU_BIAS;
    ex = 3'd0;
    for (int b = 1; b < 8; b++) begin
      if (mag[b+7]) ex = 3'(b);
    end
    mant = 4'(mag >> ({1'b0, ex} + 4'd3));
    return ~{s[15], ex, mant};
  endfunction

  // A-law code -> linear, segment midpoint
  function automatic logic [SAMPLE_W-1:0] alaw_expand(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0]   a;
    logic [SAMPLE_W-1:0] t;
    a = c ^ ALAW_MASK;
    t = {8'd0, a[3:0], 4'd0};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else                t = (t + 16'd264) << (a[6:4] - 3'd1);
    return a[7] ? t : (16'd0 - t);
  endfunction

  // linear -> A-law code
  function automatic logic [CODE_W-1:0] alaw_compress(input logic [SAMPLE_W-1:0] s);
    logic [11:0] q;
    logic [2:0]  seg;
    logic [3:0]  mant;
    q = s[15] ? ~s[14:3] : s[14:3];
    seg = 3'd0;
    for (int b = 5; b < 12; b++) begin
      if (q[b]) seg = 3'(b - 4);
    end
    mant = (seg < 3'd2) ? q[4:1] : 4'(q >> seg);
    return {~s[15], seg, mant} ^ ALAW_MASK;
  endfunction

  function automatic logic [SAMPLE_W-1:0] decode_word(input pcm_fmt_e f,
                                                      input logic [SAMPLE_W-1:0] w);
    logic [CODE_W-1:0] hi;
    hi = w[SAMPLE_W-1:PAD_W];
    case (f)
      FMT_ULIN8: return ulin8_expand(hi);
      FMT_MULAW: return ulaw_expand(hi);
      FMT_ALAW:  return alaw_expand(hi);
      default:   return w;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] encode_sample(input pcm_fmt_e f,
                                                        input logic [SAMPLE_W-1:0] s);
    case (f)
      FMT_ULIN8: return {ulin8_compress(s), {PAD_W{1'b0}}};
      FMT_MULAW: return {ulaw_compress(s), {PAD_W{1'b0}}};
      FMT_ALAW:  return {alaw_compress(s), {PAD_W{1'b0}}};
      default:   return s;
    endcase
  endfunction

endpackage

// File: rtl/pcm_fmt_hold.sv
module pcm_fmt_hold
  import pcm_fmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FMT_W-1:0]     fmt_sel,
  input  logic                 busy,
  output pcm_fmt_e             fmt_q
);

  logic fmt_take;
  assign fmt_take = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fmt_q <= FMT_LIN16;
    else if (fmt_take) fmt_q <= pcm_fmt_e'(fmt_sel);
  end

  // R10
  fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fmt_q));

endmodule

// File: rtl/pcm_dec_stage.sv
module pcm_dec_stage
  import pcm_fmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pcm_fmt_e             fmt,
  input  logic                 in_vld,
  input  logic [SAMPLE_W-1:0]  in_word,
  output logic                 out_vld,
  output logic [SAMPLE_W-1:0]  out_lin
);

  logic                dec_fire;
  logic [SAMPLE_W-1:0] dec_next;
  pcm_fmt_e            used_fmt_q;

  assign dec_fire = in_vld;
  assign dec_next = decode_word(fmt, in_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_lin    <= '0;
      used_fmt_q <= FMT_LIN16;
    end else begin
      out_vld <= dec_fire;
      if (dec_fire) begin
        out_lin    <= dec_next;
        used_fmt_q <= fmt;
      end
    end
  end

  // R2
  dec_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R2
  dec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R3
  dec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fmt == FMT_LIN16) |=> out_lin == $past(in_word));
  // R11
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_lin));
  // R5
  dec_mu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && used_fmt_q == FMT_MULAW) |->
      ($signed(out_lin) <= 32124 && $signed(out_lin) >= -32124));

endmodule

// File: rtl/pcm_enc_stage.sv
module pcm_enc_stage
  import pcm_fmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pcm_fmt_e             fmt,
  input  logic                 in_vld,
  input  logic [SAMPLE_W-1:0]  in_lin,
  output logic                 out_vld,
  output logic [SAMPLE_W-1:0]  out_word
);

  logic                enc_fire;
  logic [SAMPLE_W-1:0] enc_next;
  pcm_fmt_e            used_fmt_q;

  assign enc_fire = in_vld;
  assign enc_next = encode_sample(fmt, in_lin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_word   <= '0;
      used_fmt_q <= FMT_LIN16;
    end else begin
      out_vld <= enc_fire;
      if (enc_fire) begin
        out_word   <= enc_next;
        used_fmt_q <= fmt;
      end
    end
  end

  // R2
  enc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R2
  enc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R9
  enc_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && used_fmt_q != FMT_LIN16) |-> out_word[PAD_W-1:0] == '0);
  // R11
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_word));

endmodule

// File: rtl/pcm_fmt_conv.sv
module pcm_fmt_conv
  import pcm_fmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FMT_W-1:0]     fmt_sel,
  input  logic                 play_vld,
  input  logic [SAMPLE_W-1:0]  play_word,
  output logic                 play_lin_vld,
  output logic [SAMPLE_W-1:0]  play_lin,
  input  logic                 cap_vld,
  input  logic [SAMPLE_W-1:0]  cap_lin,
  output logic                 cap_word_vld,
  output logic [SAMPLE_W-1:0]  cap_word
);

  logic     stream_busy;
  pcm_fmt_e fmt_live;

  assign stream_busy = play_vld | cap_vld;

  pcm_fmt_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_sel (fmt_sel),
    .busy    (stream_busy),
    .fmt_q   (fmt_live)
  );

  pcm_dec_stage u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt     (fmt_live),
    .in_vld  (play_vld),
    .in_word (play_word),
    .out_vld (play_lin_vld),
    .out_lin (play_lin)
  );

  pcm_enc_stage u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt_live),
    .in_vld   (cap_vld),
    .in_lin   (cap_lin),
    .out_vld  (cap_word_vld),
    .out_word (cap_word)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!play_lin_vld && !cap_word_vld && play_lin == '0 && cap_word == '0));

endmodule

// File: tb/pcm_fmt_conv_tb.sv
module pcm_fmt_conv_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        play_vld = 1'b0;
  logic [15:0] play_word = '0;
  logic        play_lin_vld;
  logic [15:0] play_lin;
  logic        cap_vld = 1'b0;
  logic [15:0] cap_lin = '0;
  logic        cap_word_vld;
  logic [15:0] cap_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcm_fmt_conv u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .play_vld(play_vld), .play_word(play_word),
    .play_lin_vld(play_lin_vld), .play_lin(play_lin),
    .cap_vld(cap_vld), .cap_lin(cap_lin),
    .cap_word_vld(cap_word_vld), .cap_word(cap_word)
  );

  // ---- reference arithmetic, written from the requirements ----
  function automatic int ref_mu_dec(input int c);
    int u, e, m, mag;
    u = 255 - c;
    e = (u / 16) % 8;
    m = u % 16;
    mag = 4 * (2 * m + 33) * (1 << e) - 132;
    return (u >= 128) ? -mag : mag;
  endfunction

  function automatic int ref_mu_enc(input int x);
    int a, b, seg, m, sg;
    sg = (x < 0) ? 1 : 0;
    a = sg ? -x : x;
    if (a > 32635) a = 32635;
    b = a + 132;
    seg = 0;
    for (int e = 1; e < 8; e++) if (b >= (128 << e)) seg = e;
    m = (b / (8 << seg)) % 16;
    return 255 - (sg * 128 + seg * 16 + m);
  endfunction

  function automatic int ref_a_dec(input int c);
    int v, seg, m, mag;
    v = c ^ 85;
    seg = (v / 16) % 8;
    m = v % 16;
    mag = (seg == 0) ? 16 * m + 8 : (16 * m + 264) * (1 << (seg - 1));
    return (v >= 128) ? mag : -mag;
  endfunction

  function automatic int ref_a_enc(input int x);
    int q, seg, m;
    q = (x >= 0) ? x / 8 : (-x - 1) / 8;
    seg = 0;
    for (int e = 1; e < 8; e++) if (q >= (16 << e)) seg = e;
    m = (seg == 0) ? (q / 2) % 16 : (q >> seg) % 16;
    return (((x >= 0) ? 128 : 0) + seg * 16 + m) ^ 85;
  endfunction

  // ---- helpers ----
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_fmt(input logic [1:0] f);
    @(negedge clk);
    fmt_sel = f; play_vld = 0; cap_vld = 0;
    @(negedge clk);
  endtask

  // drive one cycle of stimulus, then read results at the next falling edge
  task automatic xfer(input logic pv, input logic [15:0] pw,
                      input logic cv, input logic [15:0] cs);
    @(negedge clk);
    play_vld = pv; play_word = pw; cap_vld = cv; cap_lin = cs;
    @(negedge clk);
    play_vld = 0; cap_vld = 0;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk("R1 play_lin_vld", {15'd0, play_lin_vld}, 16'd0);
    chk("R1 cap_word_vld", {15'd0, cap_word_vld}, 16'd0);
    chk("R1 play_lin", play_lin, 16'd0);
    chk("R1 cap_word", cap_word, 16'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 play_lin after release", play_lin, 16'd0);
    chk("R1 cap_word_vld after release", {15'd0, cap_word_vld}, 16'd0);
  endtask

  task automatic t_lin16();
    logic [15:0] pats [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hA5C3};
    set_fmt(2'd0);
    foreach (pats[i]) begin
      xfer(1, pats[i], 1, ~pats[i]);
      chk("R2 play valid", {15'd0, play_lin_vld}, 16'd1);
      chk("R2 cap valid", {15'd0, cap_word_vld}, 16'd1);
      chk("R3 decode pass", play_lin, pats[i]);
      chk("R3 encode pass", cap_word, ~pats[i]);
    end
  endtask

  task automatic t_ulin8();
    set_fmt(2'd1);
    for (int c = 0; c < 256; c += 17) begin
      logic [7:0] cb = 8'(c);
      xfer(1, {cb, 8'(c * 7 + 3)}, 1, {cb, 8'hFF});
      chk("R4 R9 unsigned decode", play_lin, {cb ^ 8'h80, 8'h00});
      chk("R4 R9 unsigned encode", cap_word, {cb ^ 8'h80, 8'h00});
    end
  endtask

  task automatic t_mulaw();
    set_fmt(2'd2);
    for (int c = 0; c < 256; c++) begin
      xfer(1, {8'(c), 8'(c ^ 8'h3C)}, 0, 16'd0);
      chk("R5 R9 mu decode", play_lin, 16'(ref_mu_dec(c)));
    end
    for (int x = -32768; x < 32768; x += 131) begin
      xfer(0, 16'd0, 1, 16'(x));
      chk("R6 mu encode", cap_word, {8'(ref_mu_enc(x)), 8'h00});
    end
    xfer(0, 0, 1, 16'h0000); chk("R6 mu zero", cap_word, 16'hFF00);
    xfer(0, 0, 1, 16'h7FFF); chk("R6 mu max", cap_word, 16'h8000);
    xfer(0, 0, 1, 16'h8000); chk("R6 mu min", cap_word, 16'h0000);
    xfer(0, 0, 1, 16'd32636); chk("R6 mu clip", cap_word, {8'(ref_mu_enc(32636)), 8'h00});
  endtask

  task automatic t_alaw();
    set_fmt(2'd3);
    for (int c = 0; c < 256; c++) begin
      xfer(1, {8'(c), 8'(255 - c)}, 0, 16'd0);
      chk("R7 R9 A decode", play_lin, 16'(ref_a_dec(c)));
    end
    for (int x = -32768; x < 32768; x += 127) begin
      xfer(0, 16'd0, 1, 16'(x));
      chk("R8 A encode", cap_word, {8'(ref_a_enc(x)), 8'h00});
    end
    xfer(0, 0, 1, 16'h0000); chk("R8 A zero", cap_word, 16'hD500);
    xfer(0, 0, 1, 16'hFFFF); chk("R8 A minus one", cap_word, 16'h5500);
    xfer(0, 0, 1, 16'h7FFF); chk("R8 A max", cap_word, 16'hAA00);
  endtask

  task automatic t_hold();
    logic [15:0] pl, cw;
    set_fmt(2'd2);
    xfer(1, 16'h8000, 1, 16'h1234);
    pl = play_lin; cw = cap_word;
    play_word = 16'h0000; cap_lin = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R11 play hold", play_lin, pl);
    chk("R11 cap hold", cap_word, cw);
    chk("R2 play valid low when idle", {15'd0, play_lin_vld}, 16'd0);
  endtask

  task automatic t_fmt_switch();
    set_fmt(2'd0);
    @(negedge clk); play_vld = 1; play_word = 16'h1234;
    @(negedge clk); chk("R10 first", play_lin, 16'h1234);
    fmt_sel = 2'd1; play_word = 16'h5678;
    @(negedge clk); chk("R10 old fmt kept", play_lin, 16'h5678);
    play_word = 16'h9ABC;
    @(negedge clk); chk("R10 still old fmt", play_lin, 16'h9ABC);
    play_vld = 0;
    @(negedge clk); play_vld = 1; play_word = 16'hC3FF;
    @(negedge clk); chk("R10 new fmt after idle", play_lin, 16'h4300);
    // capture strobe alone also blocks the change
    fmt_sel = 2'd0; play_vld = 0; cap_vld = 1; cap_lin = 16'h1234;
    @(negedge clk); chk("R10 cap blocks change", cap_word, 16'h9200);
    cap_lin = 16'h0101;
    @(negedge clk); chk("R10 cap still unsigned", cap_word, 16'h8100);
    cap_vld = 0;
    @(negedge clk);
    xfer(0, 0, 1, 16'h0101);
    chk("R10 cap new fmt", cap_word, 16'h0101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lin16();
    t_ulin8();
    t_mulaw();
    t_alaw();
    t_hold();
    t_fmt_switch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule